// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block models a small synchronous static memory whose word is split into four 9-bit lanes, each lane holding one data byte and one parity bit. Address, control and write data are captured on a rising clock edge, the array is updated or read on the following edge, and read data leaves through an output register. A read therefore costs two edges from the captured address to valid data. The block has separate input and output data buses. A drive flag shows when a bidirectional pad built around the block would be driving.

An access opens with one of two address strobes. The processor strobe is gated by the chip enable and always opens as a read. The cache strobe takes its write controls on the same edge as the address. While a burst is open, cycles without either strobe continue the burst at an address that an external burst sequencer supplies on its own input. The block generates no burst addresses itself.

All data and control pins are plain, cycle-by-cycle pins with no valid/ready handshake. The block never applies back-pressure, and every sampled edge is taken as a command. The output-enable and sleep pins act without a clock.

Top module: `sbw_sram`

## Requirements
- R1: With `write_all_n` low on a sampled edge that writes, all four lanes of the addressed word take the input data, whatever `lane_gate_n` and `lane_we_n` hold.
- R2: With `write_all_n` high and `lane_gate_n` low, each lane whose `lane_we_n` bit is low is written and the others keep their old contents. Any combination of lanes may be written in one cycle.
- R3: With `write_all_n` and `lane_gate_n` both high, the cycle is a read and no lane is modified, whatever `lane_we_n` holds.
- R4: Lane i (i = 0..3) is made of `wr_byte[8i+7:8i]` plus `wr_par[i]` on the write side, and of `rd_byte[8i+7:8i]` plus `rd_par[i]` on the read side.
- R5: An access opened by the processor strobe (`proc_strobe_n` low, `chip_en_n` low, chip selected) never writes on its opening edge. The write pins are honoured on the next edge, which continues at `burst_addr`.
- R6: The block is deselected on an edge where `chip_en_n` is high and `cache_strobe_n` is low. It is also deselected on an edge where `chip_en_n` is low, either strobe is low, and `sel_hi` is low or `sel_lo_n` is high. A deselected block drops `rd_drive`, and later strobe-free cycles neither read nor write.
- R7: Read data for an address captured on edge k is valid on `rd_byte`/`rd_par` after edge k+1, and `rd_drive` rises only then.
- R8: Whenever the write pins request a write (`write_all_n` low, or `lane_gate_n` low with any `lane_we_n` bit low), `rd_drive` is low at once, without a clock edge.
- R9: `out_en_n` high forces `rd_drive` low at once, while the registered read data stays unchanged.
- R10: While `sleep` is high, no clock edge changes any state: memory contents, the output register and the pipeline all hold, and `rd_drive` is low.
- R11: After a deselecting edge k, `rd_drive` still shows the read captured before edge k. It is low from edge k+1 on, with no further bubble.
- R12: A strobe-free cycle inside an open access reads or writes the word at `burst_addr`, and its read data follows the same two-edge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state (array not cleared) |
| sleep | input | 1 | High gates every state update and turns off the output drive |
| chip_en_n | input | 1 | Active-low chip enable; also gates the processor strobe |
| sel_hi | input | 1 | Active-high chip select |
| sel_lo_n | input | 1 | Active-low chip select |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| cache_strobe_n | input | 1 | Cache-controller address strobe, active low |
| addr | input | ADDR_W | Address taken when a strobe opens an access |
| burst_addr | input | ADDR_W | Address from the external burst sequencer for strobe-free cycles |
| write_all_n | input | 1 | Active-low write of all lanes |
| lane_gate_n | input | 1 | Active-low gate that passes the per-lane enables |
| lane_we_n | input | LANES | Per-lane active-low write enables |
| out_en_n | input | 1 | Active-low asynchronous output enable |
| wr_byte | input | LANES*8 | Write data bytes |
| wr_par | input | LANES | Write parity bits, one per lane |
| rd_byte | output | LANES*8 | Registered read data bytes |
| rd_par | output | LANES | Registered read parity bits |
| rd_drive | output | 1 | High when the read data would be driven onto a pad |

## Verification
Every result is due at a fixed edge. A write captured on edge k lands in the array at edge k+1. Read data for an address captured on edge k appears after edge k+1. A deselect on edge k clears the drive flag after edge k+1. The output-enable, write-request and sleep effects on the drive flag need no edge. The bench drives inputs on falling edges and samples on the falling edge that follows the edge at which each result is due. For the asynchronous effects it samples a nanosecond after the change, within the same half cycle. Writes are checked by reading them back through the normal read path, so every expected word is built from the lane rules alone.

// File: rtl/sbw_sram_pkg.sv
package sbw_sram_pkg;
  typedef enum logic [1:0] {
    CYC_CONT   = 2'd0,
    CYC_PSTART = 2'd1,
    CYC_CSTART = 2'd2,
    CYC_DESEL  = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/sbw_sram_decode.sv
module sbw_sram_decode
  import sbw_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             chip_en_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             proc_strobe_n,
  input  logic             cache_strobe_n,
  input  logic             write_all_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_we_n,
  output cyc_kind_e        kind,
  output logic [LANES-1:0] lane_req,
  output logic             wr_req
);
  logic chip_sel;
  assign chip_sel = sel_hi && !sel_lo_n;

  // Write pins: the global write overrides the gated per-lane enables.
  always_comb begin
    if (!write_all_n)      lane_req = '1;
    else if (!lane_gate_n) lane_req = ~lane_we_n;
    else                   lane_req = '0;
  end
  assign wr_req = |lane_req;

  // The processor strobe counts only while the chip enable is low, and it
  // wins over the cache strobe.
  always_comb begin
    if (!chip_en_n && !proc_strobe_n)
      kind = chip_sel ? CYC_PSTART : CYC_DESEL;
    else if (!cache_strobe_n)
      kind = (!chip_en_n && chip_sel) ? CYC_CSTART : CYC_DESEL;
    else
      kind = CYC_CONT;
  end
endmodule

// File: rtl/sbw_sram_front.sv
module sbw_sram_front
  import sbw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  cyc_kind_e         kind,
  input  logic [LANES-1:0]  lane_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] burst_addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              acc_q,
  output logic [LANES-1:0]  wr_lanes_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] wdata_q
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      acc_q      <= 1'b0;
      wr_lanes_q <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else if (awake) begin
      wdata_q <= wdata;
      unique case (kind)
        CYC_PSTART: begin
          open_q     <= 1'b1;
          acc_q      <= 1'b1;
          addr_q     <= addr;
          wr_lanes_q <= '0;
        end
        CYC_CSTART: begin
          open_q     <= 1'b1;
          acc_q      <= 1'b1;
          addr_q     <= addr;
          wr_lanes_q <= lane_req;
        end
        CYC_DESEL: begin
          open_q     <= 1'b0;
          acc_q      <= 1'b0;
          wr_lanes_q <= '0;
        end
        default: begin
          acc_q      <= open_q;
          wr_lanes_q <= open_q ? lane_req : '0;
          if (open_q) addr_q <= burst_addr;
        end
      endcase
    end
  end

  // No lane may be written while no access is registered.
  AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && kind == CYC_CONT && !open_q) |=> (wr_lanes_q == '0)); // R6
endmodule

// File: rtl/sbw_sram_array.sv
module sbw_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic              acc_q,
  input  logic [LANES-1:0]  wr_lanes_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [WORD_W-1:0] wdata_q,
  output logic [WORD_W-1:0] rdata_q,
  output logic              rd_vld_q
);
  logic rd_now;
  assign rd_now = acc_q && (wr_lanes_q == '0);

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (awake && acc_q && wr_lanes_q[ln])
        mem[addr_q] <= wdata_q[ln*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               q <= '0;
      else if (awake && rd_now) q <= mem[addr_q];
    end

    assign rdata_q[ln*LANE_W +: LANE_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_vld_q <= 1'b0;
    else if (awake) rd_vld_q <= rd_now;
  end

  // A registered write cycle never reports read data on the next edge.
  AST_WRITE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && acc_q && (wr_lanes_q != '0)) |=> !rd_vld_q); // R8
endmodule

// File: rtl/sbw_sram.sv
module sbw_sram
  import sbw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int LANE_W = BYTE_W + 1,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    chip_en_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    proc_strobe_n,
  input  logic                    cache_strobe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W-1:0]       burst_addr,
  input  logic                    write_all_n,
  input  logic                    lane_gate_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    out_en_n,
  input  logic [LANES*BYTE_W-1:0] wr_byte,
  input  logic [LANES-1:0]        wr_par,
  output logic [LANES*BYTE_W-1:0] rd_byte,
  output logic [LANES-1:0]        rd_par,
  output logic                    rd_drive
);
  cyc_kind_e         kind;
  logic [LANES-1:0]  lane_req;
  logic              wr_req;
  logic              awake;
  logic              acc_q;
  logic [LANES-1:0]  wr_lanes_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata, wdata_q, rdata_q;
  logic              rd_vld_q;

  assign awake = !sleep;

  // Lane i = {parity bit i, byte i}.
  for (genvar ln = 0; ln < LANES; ln++) begin : g_pack
    assign wdata[ln*LANE_W +: LANE_W] = {wr_par[ln], wr_byte[ln*BYTE_W +: BYTE_W]};
    assign rd_byte[ln*BYTE_W +: BYTE_W] = rdata_q[ln*LANE_W +: BYTE_W];
    assign rd_par[ln] = rdata_q[ln*LANE_W + BYTE_W];
  end

  sbw_sram_decode #(.LANES(LANES)) u_decode (
    .chip_en_n      (chip_en_n),
    .sel_hi         (sel_hi),
    .sel_lo_n       (sel_lo_n),
    .proc_strobe_n  (proc_strobe_n),
    .cache_strobe_n (cache_strobe_n),
    .write_all_n    (write_all_n),
    .lane_gate_n    (lane_gate_n),
    .lane_we_n      (lane_we_n),
    .kind           (kind),
    .lane_req       (lane_req),
    .wr_req         (wr_req)
  );

  sbw_sram_front #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .awake      (awake),
    .kind       (kind),
    .lane_req   (lane_req),
    .addr       (addr),
    .burst_addr (burst_addr),
    .wdata      (wdata),
    .acc_q      (acc_q),
    .wr_lanes_q (wr_lanes_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q)
  );

  sbw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .awake      (awake),
    .acc_q      (acc_q),
    .wr_lanes_q (wr_lanes_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .rdata_q    (rdata_q),
    .rd_vld_q   (rd_vld_q)
  );

  assign rd_drive = rd_vld_q && !out_en_n && awake && !wr_req;

  AST_PSTART_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !chip_en_n && !proc_strobe_n && sel_hi && !sel_lo_n)
      |=> (wr_lanes_q == '0)); // R5
  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && kind == CYC_CSTART && !write_all_n) |=> (wr_lanes_q == '1)); // R1
  AST_SLEEP_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(rd_byte) && $stable(rd_par))); // R10
  AST_DESEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && kind == CYC_DESEL) ##1 !sleep |=> !rd_drive); // R11
  AST_READ_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && kind == CYC_CSTART && !wr_req) ##1 !sleep |=> rd_vld_q); // R7
endmodule

// File: tb/sbw_sram_tb.sv
module sbw_sram_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, sleep, chip_en_n, sel_hi, sel_lo_n;
  logic        proc_strobe_n, cache_strobe_n;
  logic [5:0]  addr, burst_addr;
  logic        write_all_n, lane_gate_n, out_en_n;
  logic [3:0]  lane_we_n;
  logic [31:0] wr_byte;
  logic [3:0]  wr_par;
  logic [31:0] rd_byte;
  logic [3:0]  rd_par;
  logic        rd_drive;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbw_sram dut_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .chip_en_n(chip_en_n),
    .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .proc_strobe_n(proc_strobe_n),
    .cache_strobe_n(cache_strobe_n), .addr(addr), .burst_addr(burst_addr),
    .write_all_n(write_all_n), .lane_gate_n(lane_gate_n), .lane_we_n(lane_we_n),
    .out_en_n(out_en_n), .wr_byte(wr_byte), .wr_par(wr_par),
    .rd_byte(rd_byte), .rd_par(rd_par), .rd_drive(rd_drive)
  );

  // Bench word packing: {parity[3:0], bytes[31:0]}.
  typedef struct packed {
    logic [5:0]  a;
    logic        gw_n;
    logic        gate_n;
    logic [3:0]  we_n;
    logic [35:0] wd;
    logic [35:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{6'd1, 1'b0, 1'b1, 4'hF, 36'h9_ABCD_1234, 36'h9_ABCD_1234}, // R1
    '{6'd1, 1'b1, 1'b0, 4'hE, 36'h0_5555_5555, 36'h8_ABCD_1255}, // R2 R4 lane 0
    '{6'd1, 1'b1, 1'b0, 4'h5, 36'hF_1122_3344, 36'hA_11CD_3355}, // R2 R4 lanes 1,3
    '{6'd1, 1'b1, 1'b1, 4'h0, 36'h0_0000_0000, 36'hA_11CD_3355}, // R3
    '{6'd1, 1'b0, 1'b1, 4'hF, 36'h5_0F0F_0F0F, 36'h5_0F0F_0F0F}, // R1 gate high
    '{6'd2, 1'b0, 1'b0, 4'h0, 36'h3_CAFE_F00D, 36'h3_CAFE_F00D}, // R1 over lanes
    '{6'd2, 1'b1, 1'b0, 4'hB, 36'hF_00EE_0000, 36'h7_CAEE_F00D}, // R2 R4 lane 2
    '{6'd1, 1'b1, 1'b1, 4'hF, 36'h0_0000_0000, 36'h5_0F0F_0F0F}  // R3 other word
  };

  task automatic chk36(string req, logic [35:0] act, logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_idle();
    chip_en_n = 1'b1; sel_hi = 1'b1; sel_lo_n = 1'b0;
    proc_strobe_n = 1'b1; cache_strobe_n = 1'b1;
    write_all_n = 1'b1; lane_gate_n = 1'b1; lane_we_n = 4'hF;
  endtask

  task automatic cache_cyc(logic [5:0] a, logic gw_n, logic gate_n,
                           logic [3:0] we_n, logic [35:0] wd);
    chip_en_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    proc_strobe_n = 1'b1; cache_strobe_n = 1'b0; addr = a;
    write_all_n = gw_n; lane_gate_n = gate_n; lane_we_n = we_n;
    {wr_par, wr_byte} = wd;
    tick();
    set_idle();
  endtask

  task automatic desel_cyc();
    set_idle();
    cache_strobe_n = 1'b0;
    tick();
    set_idle();
  endtask

  task automatic read_word(logic [5:0] a, output logic [35:0] w);
    cache_cyc(a, 1'b1, 1'b1, 4'hF, 36'h0);
    tick();
    w = {rd_par, rd_byte};
  endtask

  task automatic desel_variant(string req, logic ce, logic s0, logic s1n,
                               logic pn, logic cn);
    cache_cyc(6'd1, 1'b1, 1'b1, 4'hF, 36'h0);
    chip_en_n = ce; sel_hi = s0; sel_lo_n = s1n;
    proc_strobe_n = pn; cache_strobe_n = cn;
    tick();
    chk1({req, " R11 read still shown after deselect edge"}, rd_drive, 1'b1);
    set_idle();
    tick();
    chk1({req, " R11 drive low one edge later"}, rd_drive, 1'b0);
  endtask

  initial begin
    logic [35:0] w, held;
    rst_n = 1'b0; sleep = 1'b0; out_en_n = 1'b0;
    addr = '0; burst_addr = '0; wr_byte = '0; wr_par = '0;
    set_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk1("reset R6 drive low", rd_drive, 1'b0);
    chk36("reset R7 output register clear", {rd_par, rd_byte}, 36'h0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      cache_cyc(VECS[i].a, VECS[i].gw_n, VECS[i].gate_n, VECS[i].we_n, VECS[i].wd);
      read_word(VECS[i].a, w);
      chk36($sformatf("vector %0d R1/R2/R3/R4 word", i), w, VECS[i].exp);
      chk1($sformatf("vector %0d R7 drive", i), rd_drive, 1'b1);
    end

    // R8 and R9: asynchronous drive control, data held.
    held = {rd_par, rd_byte};
    lane_gate_n = 1'b0; lane_we_n = 4'hE; #1;
    chk1("R8 byte write request drops drive", rd_drive, 1'b0);
    lane_gate_n = 1'b1; lane_we_n = 4'hF; write_all_n = 1'b0; #1;
    chk1("R8 global write request drops drive", rd_drive, 1'b0);
    write_all_n = 1'b1; #1;
    chk1("R8 drive back after request removed", rd_drive, 1'b1);
    out_en_n = 1'b1; #1;
    chk1("R9 output enable high drops drive", rd_drive, 1'b0);
    chk36("R9 data held", {rd_par, rd_byte}, held);
    out_en_n = 1'b0; #1;
    chk1("R9 drive back", rd_drive, 1'b1);

    // R7: exact latency from a clean deselected state.
    cache_cyc(6'd5, 1'b0, 1'b1, 4'hF, 36'h6_1357_9BDF);
    desel_cyc();
    tick();
    chk1("R7 idle before read", rd_drive, 1'b0);
    cache_cyc(6'd5, 1'b1, 1'b1, 4'hF, 36'h0);
    chk1("R7 not yet valid after address edge", rd_drive, 1'b0);
    tick();
    chk1("R7 valid after second edge", rd_drive, 1'b1);
    chk36("R7 data after second edge", {rd_par, rd_byte}, 36'h6_1357_9BDF);

    // R10: sleep freezes everything.
    held = {rd_par, rd_byte};
    sleep = 1'b1; #1;
    chk1("R10 sleep drops drive", rd_drive, 1'b0);
    chip_en_n = 1'b0; cache_strobe_n = 1'b0; addr = 6'd5;
    write_all_n = 1'b0; {wr_par, wr_byte} = 36'h0_DEAD_BEEF;
    repeat (3) tick();
    chk36("R10 output register held", {rd_par, rd_byte}, held);
    set_idle();
    sleep = 1'b0;
    desel_cyc();
    read_word(6'd5, w);
    chk36("R10 memory retained", w, 36'h6_1357_9BDF);

    // R5: processor strobe ignores write pins on its opening edge.
    cache_cyc(6'd9, 1'b0, 1'b1, 4'hF, 36'h1_0000_0099);
    desel_cyc();
    chip_en_n = 1'b0; proc_strobe_n = 1'b0; addr = 6'd9;
    write_all_n = 1'b0; {wr_par, wr_byte} = 36'hF_FFFF_FFFF;
    tick();
    set_idle();
    burst_addr = 6'd9; write_all_n = 1'b0; {wr_par, wr_byte} = 36'h2_2468_ACE0;
    tick();
    set_idle();
    chk36("R5 opening edge read old word", {rd_par, rd_byte}, 36'h1_0000_0099);
    desel_cyc();
    read_word(6'd9, w);
    chk36("R5 write taken on next edge", w, 36'h2_2468_ACE0);

    // R12: burst continuation at the sequencer address.
    cache_cyc(6'd3, 1'b0, 1'b1, 4'hF, 36'h3_3333_3333);
    cache_cyc(6'd4, 1'b0, 1'b1, 4'hF, 36'h4_4444_4444);
    burst_addr = 6'd4;
    cache_cyc(6'd3, 1'b1, 1'b1, 4'hF, 36'h0);
    tick();
    chk36("R12 first beat", {rd_par, rd_byte}, 36'h3_3333_3333);
    tick();
    chk36("R12 continued beat at burst_addr", {rd_par, rd_byte}, 36'h4_4444_4444);
    desel_cyc();
    write_all_n = 1'b0; {wr_par, wr_byte} = 36'h0_BAD0_BAD0;
    tick();
    set_idle();
    read_word(6'd4, w);
    chk36("R6 R12 continue ignored when deselected", w, 36'h4_4444_4444);

    // R6 deselect forms, each checked for R11 timing.
    desel_variant("R6 chip enable high with cache strobe", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    desel_variant("R6 proc strobe with sel_hi low", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    desel_variant("R6 cache strobe with sel_lo_n high", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule